// File: doc/BRIEF.md
# Flat Page-Table Address Translator

This block converts 32-bit I/O virtual addresses issued by a DMA client into physical addresses. Pages are 4 KiB, so the virtual page number is the upper 20 bits of the address. The page table is a single flat array of 2^20 32-bit descriptors, 4 MiB in all, starting at a configurable base. The entry for a page sits at the base plus four times its page number. A descriptor marks a usable page with bit 1 and a non-secure page with bit 3. Its upper 20 bits hold the physical frame.

An eight-entry fully associative cache holds recent translations. A lookup that hits answers in the next cycle. A miss issues exactly one descriptor read on a simple request/response memory port. When the fetched descriptor is not usable, the block does not abort the access. It reports a fault and steers the access into a small protect buffer, whose 128-byte-aligned address comes from a configuration input. Requests use a valid/ready handshake, and a new request is taken only when no table read is in flight.

Top module: `pt_xlate`

## Requirements
- R1: Out of reset, `req_ready_o` is 1 and both `rsp_valid_o` and `mem_req_o` are 0. A request is taken in a cycle where `req_valid_i` and `req_ready_o` are both high. `req_ready_o` stays low from the cycle after a missing request is taken until its response is produced.
- R2: A request whose page is held in the cache is answered with `rsp_valid_o` in the cycle after it is taken, and it causes no memory read. Hitting requests can be taken and answered one per cycle.
- R3: A miss raises `mem_req_o` for exactly one cycle, in the cycle right after the request is taken. `mem_addr_o` then equals `cfg_table_base_i + iova[31:12]*4`.
- R4: A descriptor with bit 1 set gives `rsp_pa_o = {desc[31:12], iova[11:0]}`, `rsp_nonsec_o = desc[3]` and `rsp_fault_o = 0`. Descriptor bits 0, 2 and 4 to 11 have no effect on the response.
- R5: A descriptor with bit 1 clear gives `rsp_fault_o = 1`, `rsp_nonsec_o = 0` and `rsp_pa_o = {cfg_protect_base_i[31:7], iova[6:0]}`. Such a page is not cached, so a repeat access reads the table again.
- R6: The cache holds 8 translations and replaces entries in round-robin order. Only valid descriptors fill it. After eight fills, the ninth fill evicts the first-filled entry, so that page misses again while the other seven still hit.
- R7: A miss is answered with `rsp_valid_o` in the cycle after `mem_rvalid_i` returns the descriptor.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_table_base_i | input | 32 | Byte address of descriptor 0 |
| cfg_protect_base_i | input | 32 | Protect buffer address (bits 6:0 ignored) |
| req_valid_i | input | 1 | Translation request present |
| req_iova_i | input | 32 | Virtual address to translate |
| req_ready_o | output | 1 | Translator can take a request |
| mem_req_o | output | 1 | Descriptor read request (one cycle) |
| mem_addr_o | output | 32 | Descriptor byte address |
| mem_rvalid_i | input | 1 | Descriptor data valid |
| mem_rdata_i | input | 32 | Descriptor data |
| rsp_valid_o | output | 1 | Translation result valid (one cycle) |
| rsp_pa_o | output | 32 | Physical address |
| rsp_fault_o | output | 1 | Translation fault, access redirected |
| rsp_nonsec_o | output | 1 | Page is non-secure |

## Verification
A cache entry holding a wrong page number or frame shows up at the ports one cycle after the next request to that page, as a wrong physical address or as an unexpected descriptor read. A stale or skipped replacement pointer goes unseen until the cache wraps. The bench therefore fills more than eight pages and then revisits all of them, which exposes a wrong eviction as a miss-versus-hit mismatch in both response timing and read count. A stuck walk state shows up within a few cycles, as `req_ready_o` staying low or as a response that arrives early or late.

// File: rtl/pt_xlate_pkg.sv
// Shared constants and descriptor decode for the flat page-table translator.
// Assumes a 32-bit address space and a 32-bit descriptor word.
package pt_xlate_pkg;
    localparam int ADDR_W       = 32;
    localparam int DESC_VLD_BIT = 1;
    localparam int DESC_NS_BIT  = 3;

    typedef struct packed {
        logic [ADDR_W-1:0] addr;
        logic              fault;
        logic              nonsec;
    } xlate_rsp_t;
endpackage

// File: rtl/pt_tlb.sv
// Fully associative translation cache with round-robin replacement.
// Assumes at most one fill per cycle and that a page is filled only after
// it missed, so entries never hold duplicate page numbers.
module pt_tlb #(
    parameter int ENTRIES = 8,
    parameter int VPN_W   = 20,
    parameter int PFN_W   = 20
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [VPN_W-1:0] lk_vpn_i,
    output logic             lk_hit_o,
    output logic [PFN_W-1:0] lk_pfn_o,
    output logic             lk_ns_o,
    input  logic             fill_i,
    input  logic [VPN_W-1:0] fill_vpn_i,
    input  logic [PFN_W-1:0] fill_pfn_i,
    input  logic             fill_ns_i
);
    localparam int IDX_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;

    logic [ENTRIES-1:0] ent_vld;
    logic [VPN_W-1:0]   ent_vpn [ENTRIES];
    logic [PFN_W-1:0]   ent_pfn [ENTRIES];
    logic [ENTRIES-1:0] ent_ns;
    logic [ENTRIES-1:0] match;
    logic [IDX_W-1:0]   rr_ptr;

    for (genvar i = 0; i < ENTRIES; i++) begin : g_ent
        // Entry storage: written only when the round-robin pointer selects it.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                ent_vld[i] <= 1'b0;
                ent_vpn[i] <= '0;
                ent_pfn[i] <= '0;
                ent_ns[i]  <= 1'b0;
            end else if (fill_i && (rr_ptr == IDX_W'(i))) begin
                ent_vld[i] <= 1'b1;
                ent_vpn[i] <= fill_vpn_i;
                ent_pfn[i] <= fill_pfn_i;
                ent_ns[i]  <= fill_ns_i;
            end
        end
        assign match[i] = ent_vld[i] && (ent_vpn[i] == lk_vpn_i);
    end

    // Replacement pointer: advances by one on every fill, wrapping at ENTRIES.
    always_ff @(posedge clk) begin
        if (!rst_n)
            rr_ptr <= '0;
        else if (fill_i)
            rr_ptr <= (rr_ptr == IDX_W'(ENTRIES - 1)) ? '0 : rr_ptr + 1'b1;
    end

    // Lookup: OR-reduce the one matching entry onto the result.
    always_comb begin
        lk_hit_o = |match;
        lk_pfn_o = '0;
        lk_ns_o  = 1'b0;
        for (int k = 0; k < ENTRIES; k++) begin
            if (match[k]) begin
                lk_pfn_o = lk_pfn_o | ent_pfn[k];
                lk_ns_o  = lk_ns_o | ent_ns[k];
            end
        end
    end
endmodule

// File: rtl/pt_walker.sv
// Single-descriptor table walk: latches the missing address, issues one
// read of base + page*4, and waits for the data to return.
// Assumes the memory answers no earlier than the cycle after the request.
module pt_walker #(
    parameter int ADDR_W     = 32,
    parameter int PAGE_SHIFT = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic [ADDR_W-1:0] iova_i,
    input  logic [ADDR_W-1:0] table_base_i,
    output logic              busy_o,
    output logic              mem_req_o,
    output logic [ADDR_W-1:0] mem_addr_o,
    input  logic              mem_rvalid_i,
    output logic              done_o,
    output logic [ADDR_W-1:0] iova_q_o
);
    localparam int VPN_W = ADDR_W - PAGE_SHIFT;

    typedef enum logic [1:0] {W_IDLE, W_FETCH, W_WAIT} wstate_t;
    wstate_t state;

    // Walk sequencing: idle -> one-cycle fetch -> wait for data -> idle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= W_IDLE;
            iova_q_o <= '0;
        end else begin
            case (state)
                W_IDLE:  if (start_i) begin
                             state    <= W_FETCH;
                             iova_q_o <= iova_i;
                         end
                W_FETCH: state <= W_WAIT;
                W_WAIT:  if (mem_rvalid_i) state <= W_IDLE;
                default: state <= W_IDLE;
            endcase
        end
    end

    // Outputs decoded from the walk state.
    always_comb begin
        busy_o     = (state != W_IDLE);
        mem_req_o  = (state == W_FETCH);
        done_o     = (state == W_WAIT) && mem_rvalid_i;
        mem_addr_o = table_base_i +
                     {{(PAGE_SHIFT-2){1'b0}}, iova_q_o[ADDR_W-1:PAGE_SHIFT], 2'b00};
    end

    logic [VPN_W-1:0] unused_vpn_w;
    assign unused_vpn_w = '0;
endmodule

// File: rtl/pt_xlate.sv
// Top of the flat page-table translator. Looks each request up in the
// translation cache; on a miss it walks one descriptor and either returns
// the mapped address or redirects the access to the protect buffer.
// Assumes the configuration inputs are stable while requests are in flight.
module pt_xlate
    import pt_xlate_pkg::*;
#(
    parameter int TLB_ENTRIES = 8,
    parameter int PAGE_SHIFT  = 12,
    parameter int PROT_SHIFT  = 7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] cfg_table_base_i,
    input  logic [ADDR_W-1:0] cfg_protect_base_i,
    input  logic              req_valid_i,
    input  logic [ADDR_W-1:0] req_iova_i,
    output logic              req_ready_o,
    output logic              mem_req_o,
    output logic [ADDR_W-1:0] mem_addr_o,
    input  logic              mem_rvalid_i,
    input  logic [ADDR_W-1:0] mem_rdata_i,
    output logic              rsp_valid_o,
    output logic [ADDR_W-1:0] rsp_pa_o,
    output logic              rsp_fault_o,
    output logic              rsp_nonsec_o
);
    localparam int VPN_W = ADDR_W - PAGE_SHIFT;

    logic              accept, walk_busy, walk_done;
    logic              hit, hit_ns;
    logic [VPN_W-1:0]  hit_pfn;
    logic [ADDR_W-1:0] walk_iova;
    logic              desc_vld, desc_ns;
    logic [VPN_W-1:0]  desc_pfn;
    xlate_rsp_t        rsp_d, rsp_q;
    logic              rsp_vld_d;

    assign req_ready_o = !walk_busy;
    assign accept      = req_valid_i && req_ready_o;

    // Descriptor fields used by the translator; other bits are don't-care.
    assign desc_vld = mem_rdata_i[DESC_VLD_BIT];
    assign desc_ns  = mem_rdata_i[DESC_NS_BIT];
    assign desc_pfn = mem_rdata_i[ADDR_W-1:PAGE_SHIFT];

    pt_tlb #(.ENTRIES(TLB_ENTRIES), .VPN_W(VPN_W), .PFN_W(VPN_W)) u_tlb (
        .clk        (clk),
        .rst_n      (rst_n),
        .lk_vpn_i   (req_iova_i[ADDR_W-1:PAGE_SHIFT]),
        .lk_hit_o   (hit),
        .lk_pfn_o   (hit_pfn),
        .lk_ns_o    (hit_ns),
        .fill_i     (walk_done && desc_vld),
        .fill_vpn_i (walk_iova[ADDR_W-1:PAGE_SHIFT]),
        .fill_pfn_i (desc_pfn),
        .fill_ns_i  (desc_ns)
    );

    pt_walker #(.ADDR_W(ADDR_W), .PAGE_SHIFT(PAGE_SHIFT)) u_walk (
        .clk          (clk),
        .rst_n        (rst_n),
        .start_i      (accept && !hit),
        .iova_i       (req_iova_i),
        .table_base_i (cfg_table_base_i),
        .busy_o       (walk_busy),
        .mem_req_o    (mem_req_o),
        .mem_addr_o   (mem_addr_o),
        .mem_rvalid_i (mem_rvalid_i),
        .done_o       (walk_done),
        .iova_q_o     (walk_iova)
    );

    // Result select: cache hit, mapped walk result, or protect redirect.
    always_comb begin
        rsp_vld_d = 1'b0;
        rsp_d     = rsp_q;
        if (accept && hit) begin
            rsp_vld_d    = 1'b1;
            rsp_d.addr   = {hit_pfn, req_iova_i[PAGE_SHIFT-1:0]};
            rsp_d.fault  = 1'b0;
            rsp_d.nonsec = hit_ns;
        end else if (walk_done) begin
            rsp_vld_d = 1'b1;
            if (desc_vld) begin
                rsp_d.addr   = {desc_pfn, walk_iova[PAGE_SHIFT-1:0]};
                rsp_d.fault  = 1'b0;
                rsp_d.nonsec = desc_ns;
            end else begin
                rsp_d.addr   = {cfg_protect_base_i[ADDR_W-1:PROT_SHIFT],
                                walk_iova[PROT_SHIFT-1:0]};
                rsp_d.fault  = 1'b1;
                rsp_d.nonsec = 1'b0;
            end
        end
    end

    // Response register: one-cycle valid pulse with held result fields.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_valid_o <= 1'b0;
            rsp_q       <= '0;
        end else begin
            rsp_valid_o <= rsp_vld_d;
            rsp_q       <= rsp_d;
        end
    end

    assign rsp_pa_o     = rsp_q.addr;
    assign rsp_fault_o  = rsp_q.fault;
    assign rsp_nonsec_o = rsp_q.nonsec;
endmodule

// File: rtl/pt_xlate_chk.sv
// Protocol checker for pt_xlate, attached with bind. Observes ports only.
module pt_xlate_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        req_valid_i,
    input logic        req_ready_o,
    input logic        mem_req_o,
    input logic        mem_rvalid_i,
    input logic        rsp_valid_o,
    input logic        rsp_fault_o,
    input logic        rsp_nonsec_o,
    input logic [24:0] rsp_pa_hi,
    input logic [24:0] prot_hi
);
    // R1: no request can be taken while a descriptor read is being issued.
    assert_busy_blocks_R1: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_o |-> !req_ready_o);

    // R3: the read is issued right after a request was taken.
    assert_fetch_after_accept_R3: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_o |-> $past(req_valid_i && req_ready_o));

    // R3: a miss issues a single one-cycle read.
    assert_single_read_R3: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_o |=> !mem_req_o);

    // R5: a fault lands in the protect buffer and is never non-secure.
    assert_fault_redirect_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid_o && rsp_fault_o) |-> (rsp_pa_hi == prot_hi && !rsp_nonsec_o));

    // R7: a response not caused by a take in the prior cycle follows returned data.
    assert_rsp_after_data_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid_o && !$past(req_valid_i && req_ready_o)) |-> $past(mem_rvalid_i));
endmodule

bind pt_xlate pt_xlate_chk u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .req_valid_i  (req_valid_i),
    .req_ready_o  (req_ready_o),
    .mem_req_o    (mem_req_o),
    .mem_rvalid_i (mem_rvalid_i),
    .rsp_valid_o  (rsp_valid_o),
    .rsp_fault_o  (rsp_fault_o),
    .rsp_nonsec_o (rsp_nonsec_o),
    .rsp_pa_hi    (rsp_pa_o[31:7]),
    .prot_hi      (cfg_protect_base_i[31:7])
);

// File: tb/sim_pt_xlate.sv
// Scoreboard bench: the driver predicts each response and queues it; the
// monitor compares responses, including their timing, as they appear.
module sim_pt_xlate;
    localparam int CLK_PERIOD = 10;
    localparam int MEM_LAT    = 3;
    localparam int TLB_N      = 8;
    localparam logic [31:0] TBL_BASE  = 32'h8000_0000;
    localparam logic [31:0] PROT_BASE = 32'h1234_56C5;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [31:0] req_iova = '0;
    logic        req_ready, mem_req, mem_rvalid = 1'b0;
    logic [31:0] mem_addr, mem_rdata = '0;
    logic        rsp_valid, rsp_fault, rsp_nonsec;
    logic [31:0] rsp_pa;

    always #(CLK_PERIOD/2) clk = ~clk;

    pt_xlate u0 (
        .clk(clk), .rst_n(rst_n),
        .cfg_table_base_i(TBL_BASE), .cfg_protect_base_i(PROT_BASE),
        .req_valid_i(req_valid), .req_iova_i(req_iova), .req_ready_o(req_ready),
        .mem_req_o(mem_req), .mem_addr_o(mem_addr),
        .mem_rvalid_i(mem_rvalid), .mem_rdata_i(mem_rdata),
        .rsp_valid_o(rsp_valid), .rsp_pa_o(rsp_pa),
        .rsp_fault_o(rsp_fault), .rsp_nonsec_o(rsp_nonsec)
    );

    typedef struct {
        logic [31:0] pa;
        logic        fault;
        logic        ns;
        logic        hit;
        int          acc;
    } exp_t;

    exp_t        q[$];
    int          checks = 0, errors = 0, cyc = 0;
    int          reads = 0, model_reads = 0;
    logic [19:0] last_vpn = '0;
    logic [19:0] m_vpn [TLB_N];
    logic        m_vld [TLB_N];
    int          m_ptr = 0;
    bit          done = 0;

    always @(posedge clk) cyc++;

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Descriptor content per page: bit1 valid unless vpn%5==3, bit3 = vpn[1], noise elsewhere.
    function automatic logic [31:0] desc_of(input logic [19:0] vpn);
        logic [11:0] low;
        low = (12'hA55 & ~12'h00A) | {8'h0, vpn[1], 1'b0, (vpn % 5) != 3, 1'b0};
        return {vpn ^ 20'hA5A5A, low};
    endfunction

    // Memory model: answers MEM_LAT cycles after a read request, checks address (R3).
    int mcnt = 0;
    logic [31:0] maddr = '0;
    always @(negedge clk) begin
        mem_rvalid = 1'b0;
        if (mem_req) begin
            reads++;
            maddr = mem_addr;
            mcnt = MEM_LAT;
            chk(mem_addr == TBL_BASE + {10'h0, last_vpn, 2'b00}, "R3 descriptor address",
                mem_addr, TBL_BASE + {10'h0, last_vpn, 2'b00});
        end else if (mcnt != 0) begin
            mcnt--;
            if (mcnt == 0) begin
                mem_rvalid = 1'b1;
                mem_rdata  = desc_of(20'((maddr - TBL_BASE) >> 2));
            end
        end
    end

    // Monitor: pops the oldest expectation and compares value and timing.
    always @(negedge clk) begin
        if (rst_n && rsp_valid) begin
            if (q.size() == 0) begin
                chk(0, "R1 unexpected response", rsp_pa, 32'h0);
            end else begin
                exp_t e;
                e = q.pop_front();
                chk(rsp_pa == e.pa, e.fault ? "R5 redirect address" : "R4 physical address", rsp_pa, e.pa);
                chk(rsp_fault == e.fault, "R5 fault flag", 32'(rsp_fault), 32'(e.fault));
                chk(rsp_nonsec == e.ns, "R4 non-secure flag", 32'(rsp_nonsec), 32'(e.ns));
                if (e.hit)
                    chk(cyc == e.acc, "R2 hit latency", cyc - e.acc, 0);
                else
                    chk(cyc == e.acc + MEM_LAT + 1, "R7 miss latency", cyc - e.acc, MEM_LAT + 1);
            end
        end
    end

    // Driver: predicts the response from the bench cache model, then issues the request.
    task automatic send(input logic [31:0] iova);
        exp_t e;
        logic [19:0] vpn;
        logic [31:0] d;
        vpn = iova[31:12];
        d = desc_of(vpn);
        e.hit = 0;
        for (int i = 0; i < TLB_N; i++)
            if (m_vld[i] && m_vpn[i] == vpn) e.hit = 1;
        if (!e.hit) begin
            model_reads++;
            if (d[1]) begin
                m_vpn[m_ptr] = vpn;
                m_vld[m_ptr] = 1;
                m_ptr = (m_ptr + 1) % TLB_N;
            end
        end
        if (d[1]) begin
            e.pa = {d[31:12], iova[11:0]};
            e.fault = 0;
            e.ns = d[3];
        end else begin
            e.pa = {PROT_BASE[31:7], iova[6:0]};
            e.fault = 1;
            e.ns = 0;
        end
        req_valid = 1'b1;
        req_iova  = iova;
        while (!req_ready) @(negedge clk);
        e.acc = cyc + 1;
        last_vpn = vpn;
        q.push_back(e);
        @(negedge clk);
        req_valid = 1'b0;
        if (!e.hit) chk(req_ready == 1'b0, "R1 ready low during walk", 32'(req_ready), 0);
    endtask

    task automatic drain();
        while (q.size() != 0) @(negedge clk);
        repeat (2) @(negedge clk);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    endtask

    initial begin
        for (int i = 0; i < TLB_N; i++) begin m_vld[i] = 0; m_vpn[i] = '0; end
        repeat (4) @(negedge clk);
        chk(req_ready == 1'b1, "R1 reset ready", 32'(req_ready), 1);
        chk(rsp_valid == 1'b0, "R1 reset rsp_valid", 32'(rsp_valid), 0);
        chk(mem_req == 1'b0, "R1 reset mem_req", 32'(mem_req), 0);
        rst_n = 1'b1;
        @(negedge clk);

        // Miss, hit on same page, faulting page twice, address extremes (R2-R5, R7).
        send(32'h0000_1234);
        send(32'h0000_1ABC);
        send(32'h0000_3004);
        send(32'h0000_3FFF);
        send(32'hFFFF_FFFF);
        send(32'h0000_0000);
        drain();
        chk(reads == model_reads, "R5 fault not cached / R2 no read on hit", reads, model_reads);

        // Back-to-back hits at full rate (R2).
        send(32'h0000_1000);
        send(32'h0000_1FFC);
        send(32'hFFFF_F000);
        send(32'h0000_0ABC);
        drain();
        chk(reads == model_reads, "R2 back-to-back hits read count", reads, model_reads);

        // Round-robin replacement: fill beyond capacity, then revisit (R6).
        for (int p = 16; p < 30; p++) send({12'h0, 8'(p), 12'h080});
        for (int p = 16; p < 30; p++) send({12'h0, 8'(p), 12'h7F0});
        send(32'h0000_1000);
        drain();
        chk(reads == model_reads, "R6 round-robin read count", reads, model_reads);
        chk(req_ready == 1'b1, "R1 idle ready", 32'(req_ready), 1);
        finish_run();
    end

    // Watchdog: a hung run counts as one failed check.
    initial begin
        repeat (20000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog expired");
        finish_run();
    end
endmodule